// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter with Fractional Baud Divisor

This block turns bytes written by software over a small register bus into asynchronous serial frames on a single output line. Each frame has one low start bit, five to eight data bits sent least significant bit first, and one high stop bit. Each bit lasts sixteen ticks of an internal rate generator. The tick period is an integer number of clocks plus a fraction in sixty-fourths. Software derives both numbers from four times the clock frequency divided by the baud rate. The quotient of that value by 64 is the integer part and the remainder is the fractional part.

Bytes wait in a transmit buffer. The buffer is sixteen entries deep when its enable bit is set and behaves as a single slot when that bit is clear. The buffer drains only while both the block enable and the transmit enable are set. The divisor and line-format registers are frozen while the block is enabled or while a character is still on the line. Software must therefore disable the block and let the line settle before it reprograms them.

Top module: `sertx_top`

## Requirements
- R1: After reset the control reads 0x0000, line control 0x0000, integer divisor 0x0001, fractional divisor 0x0000 and flags 0x0000, and the line is high.
- R2: A frame is a low start bit, then N data bits LSB first, then a high stop bit. N is 5 + line-control bits [6:5] (00→5, 01→6, 10→7, 11→8). Data bits above N are not sent.
- R3: Tick t of a frame (t counted from 1) falls I*t + floor((t-1)*F/64) clocks after the start bit appears. I is the integer divisor at offset 0x24, with 0 acting as 1. F is the 6-bit fraction at offset 0x28. Every bit lasts 16 ticks, and the frame ends on tick 16*(N+2).
- R4: Writes to offsets 0x24, 0x28 and 0x2C are ignored while control bit 0 is 1 or while a character is being shifted out. At other times they take effect.
- R5: No frame starts unless control bit 0 (block enable) and control bit 8 (transmit enable) are both 1.
- R6: Flag bit 5 (offset 0x18) is 1 when the buffer holds 16 bytes with line-control bit 4 set, or holds 1 byte with that bit clear.
- R7: A write to the data register (offset 0x00) while flag bit 5 is 1 is discarded and never transmitted.
- R8: Flag bit 3 is 1 while the buffer holds any byte or a character is being shifted, and 0 otherwise.
- R9: An accepted line-control write that clears bit 4 while it was set empties the buffer.
- R10: Clearing control bit 0 during a frame lets that frame finish normally. No further frame starts while the bit stays 0, and the unsent bytes stay buffered.
- R11: The line is high whenever no character is being shifted. Queued bytes follow each other with no idle gap, in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 6 | Register byte offset |
| busWrData | input | 16 | Register write data |
| busRdData | output | 16 | Register read data for busAddr (combinational) |
| txOut | output | 1 | Serial output line |

## Verification
The hardest situations to reach are those where configuration, buffer state and the shifter interact in time. Examples are a reprogramming attempt arriving after the enable is cleared but before the current character has left, and a discarded write when the buffer is full. The bench reaches the first case with a forked stimulus thread: it waits for the start bit, drops the enable a few dozen clocks into the frame and immediately writes a new divisor. It reaches the second by filling the buffer with the block disabled. Fractional rounding errors only show over a whole frame, so for each random divisor pair the bench times the drop of the busy flag to the exact clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 6;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IDIV = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_FDIV = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_LINE = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h30;

  typedef struct packed {
    logic [INT_W-1:0]  intDiv;
    logic [FRAC_W-1:0] fracDiv;
    logic [1:0]        wordSel;
    logic              fifoOn;
    logic              uartOn;
    logic              txOn;
  } cfg_t;

  typedef struct packed {
    logic              push;
    logic              flush;
    logic [BYTE_W-1:0] byteIn;
  } strobe_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              fifoFull,
  input  logic              busy,
  input  logic              shifting,
  output cfg_t              cfg,
  output strobe_t           stb
);
  cfg_t cfgQ;
  logic cfgLock;

  assign cfgLock = cfgQ.uartOn | shifting;
  assign cfg     = cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.intDiv  <= INT_W'(1);
      cfgQ.fracDiv <= '0;
      cfgQ.wordSel <= 2'b00;
      cfgQ.fifoOn  <= 1'b0;
      cfgQ.uartOn  <= 1'b0;
      cfgQ.txOn    <= 1'b0;
    end else if (busWr) begin
      case (busAddr)
        OFS_IDIV: if (!cfgLock) cfgQ.intDiv <= busWrData[INT_W-1:0];
        OFS_FDIV: if (!cfgLock) cfgQ.fracDiv <= busWrData[FRAC_W-1:0];
        OFS_LINE: if (!cfgLock) begin
          cfgQ.wordSel <= busWrData[6:5];
          cfgQ.fifoOn  <= busWrData[4];
        end
        OFS_CTRL: begin
          cfgQ.uartOn <= busWrData[0];
          cfgQ.txOn   <= busWrData[8];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.push   = busWr && (busAddr == OFS_DATA) && !fifoFull;
    stb.flush  = busWr && (busAddr == OFS_LINE) && !cfgLock && cfgQ.fifoOn && !busWrData[4];
    stb.byteIn = busWrData[BYTE_W-1:0];
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_FLAG: begin
        busRdData[5] = fifoFull;
        busRdData[3] = busy;
      end
      OFS_IDIV: busRdData[INT_W-1:0]  = cfgQ.intDiv;
      OFS_FDIV: busRdData[FRAC_W-1:0] = cfgQ.fracDiv;
      OFS_LINE: begin
        busRdData[6:5] = cfgQ.wordSel;
        busRdData[4]   = cfgQ.fifoOn;
      end
      OFS_CTRL: begin
        busRdData[0] = cfgQ.uartOn;
        busRdData[8] = cfgQ.txOn;
      end
      default: ;
    endcase
  end

  // R4
  idiv_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLock |=> $stable(cfgQ.intDiv));
  // R4
  line_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLock |=> $stable({cfgQ.wordSel, cfgQ.fifoOn, cfgQ.fracDiv}));
endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              run,
  input  logic [INT_W-1:0]  intDiv,
  input  logic [FRAC_W-1:0] fracDiv,
  output logic              tick
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [INT_W-1:0]  baseDiv;
  logic [FRAC_W-1:0] acc;
  logic              stretch;

  assign baseDiv = (intDiv == '0) ? INT_W'(1) : intDiv;
  assign limit   = {1'b0, baseDiv} + CNT_W'(stretch);
  assign tick    = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= CNT_W'(1);
      acc     <= '0;
      stretch <= 1'b0;
    end else if (restart || !run) begin
      cnt     <= CNT_W'(1);
      acc     <= '0;
      stretch <= 1'b0;
    end else if (tick) begin
      cnt            <= CNT_W'(1);
      {stretch, acc} <= {1'b0, acc} + {1'b0, fracDiv};
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R3
  period_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    run |-> cnt <= limit);
endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  strobe_t stb,
  output logic    fifoFull,
  output logic    busy,
  output logic    shifting,
  output logic    txOut
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              fifoEmpty;

  logic [BYTE_W-1:0] frameByte;
  logic [3:0]        tickCnt, bitPos, nxtPos, dataBits, stopPos;
  logic [2:0]        bitSel;
  logic              txOutQ, tick, bitDone, frameDone, canStart, nxtVal;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = cfg.fifoOn ? (count == CNT_W'(DEPTH)) : !fifoEmpty;
  assign busy      = !fifoEmpty || shifting;
  assign txOut     = txOutQ;

  assign dataBits  = 4'd5 + {2'b00, cfg.wordSel};
  assign stopPos   = dataBits + 4'd1;
  assign bitDone   = shifting && tick && (tickCnt == 4'hF);
  assign frameDone = bitDone && (bitPos == stopPos);
  assign canStart  = cfg.uartOn && cfg.txOn && !fifoEmpty && (!shifting || frameDone);
  assign nxtPos    = bitPos + 4'd1;
  assign bitSel    = nxtPos[2:0] - 3'd1;
  assign nxtVal    = (nxtPos <= dataBits) ? frameByte[bitSel] : 1'b1;

  sertx_baud #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_baud (
    .clk     (clk),
    .rstN    (rstN),
    .restart (canStart),
    .run     (shifting),
    .intDiv  (cfg.intDiv),
    .fracDiv (cfg.fracDiv),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= stb.byteIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (canStart) rdPtr <= rdPtr + PTR_W'(1);
      case ({stb.push, canStart})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifting  <= 1'b0;
      tickCnt   <= '0;
      bitPos    <= '0;
      frameByte <= '0;
      txOutQ    <= 1'b1;
    end else if (canStart) begin
      shifting  <= 1'b1;
      tickCnt   <= '0;
      bitPos    <= '0;
      frameByte <= mem[rdPtr];
      txOutQ    <= 1'b0;
    end else if (frameDone) begin
      shifting <= 1'b0;
      txOutQ   <= 1'b1;
    end else if (shifting && tick) begin
      tickCnt <= tickCnt + 4'd1;
      if (tickCnt == 4'hF) begin
        bitPos <= nxtPos;
        txOutQ <= nxtVal;
      end
    end
  end

  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shifting |-> txOutQ);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shifting) |-> !txOutQ);
  // R5
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shifting) |-> $past(cfg.uartOn && cfg.txOn));
  // R6
  single_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.fifoOn |-> count <= CNT_W'(1));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> count == '0);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              txOut
);
  cfg_t    cfg;
  strobe_t stb;
  logic    fifoFull, busy, shifting;

  sertx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .fifoFull  (fifoFull),
    .busy      (busy),
    .shifting  (shifting),
    .cfg       (cfg),
    .stb       (stb)
  );

  sertx_datapath #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .stb      (stb),
    .fifoFull (fifoFull),
    .busy     (busy),
    .shifting (shifting),
    .txOut    (txOut)
  );
endmodule

// File: tb/sertx_top_tb.sv
`timescale 1ns/1ps
module sertx_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        txOut;
  int nChecks = 0;
  int nFail = 0;

  localparam logic [5:0] A_DATA = 6'h00, A_FLAG = 6'h18, A_IDIV = 6'h24,
                         A_FDIV = 6'h28, A_LINE = 6'h2C, A_CTRL = 6'h30;

  always #2 clk = ~clk;

  sertx_top u_dut (.clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
                   .busWrData(busWrData), .busRdData(busRdData), .txOut(txOut));

  function automatic int tickTime(input int t, input int iDiv, input int fDiv);
    int effI;
    effI = (iDiv == 0) ? 1 : iDiv;
    return t * effI + ((t - 1) * fDiv) / 64;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output int v);
    @(negedge clk);
    busAddr = a;
    #1 v = int'(busRdData);
  endtask

  task automatic stayHigh(input int n, input string tag);
    int lowSeen;
    lowSeen = 0;
    repeat (n) begin
      @(negedge clk);
      if (txOut !== 1'b1) lowSeen = 1;
    end
    check(tag, lowSeen, 0);
  endtask

  // Receives one frame; samples every bit at its middle tick.
  task automatic rxFrame(input int wl, input int iDiv, input int fDiv, input bit measureEnd,
                         output int data, output int framing, output int preEdge,
                         output int postEdge, output int endAt);
    int elapsed, nb, target;
    nb = wl + 5; data = 0; framing = 1; endAt = -1; preEdge = -1; postEdge = -1;
    do @(negedge clk); while (txOut !== 1'b0);
    elapsed = 0;
    for (int j = 0; j <= nb + 1; j++) begin
      target = tickTime(16 * j + 8, iDiv, fDiv);
      while (elapsed < target) begin
        @(negedge clk);
        elapsed++;
        if (elapsed == tickTime(16, iDiv, fDiv) - 1) preEdge = int'(txOut);
        if (elapsed == tickTime(16, iDiv, fDiv)) postEdge = int'(txOut);
      end
      if (j == 0 && txOut !== 1'b0) framing = 0;
      else if (j == nb + 1 && txOut !== 1'b1) framing = 0;
      else if (j > 0 && j <= nb && txOut === 1'b1) data = data | (1 << (j - 1));
    end
    if (measureEnd) begin
      do begin
        @(negedge clk);
        elapsed++;
        busAddr = A_FLAG;
        #1;
      end while (busRdData[3] === 1'b1 && elapsed < 100000);
      endAt = elapsed;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int v, d, fr, pre, post, endAt;
    logic [7:0] sent [16];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(A_CTRL, v); check("R1 control reset", v, 0);
    busRead(A_LINE, v); check("R1 line reset", v, 0);
    busRead(A_IDIV, v); check("R1 int divisor reset", v, 1);
    busRead(A_FDIV, v); check("R1 frac divisor reset", v, 0);
    busRead(A_FLAG, v); check("R1 flags reset", v, 0);
    check("R1 line idles high", int'(txOut), 1);

    // R4 unlocked configuration
    busWrite(A_IDIV, 16'd3); busWrite(A_FDIV, 16'd0); busWrite(A_LINE, 16'h0070);
    busRead(A_IDIV, v); check("R4 unlocked int divisor write", v, 3);
    busRead(A_LINE, v); check("R4 unlocked line write", v, 'h70);

    // R6 / R7 / R8 fill buffer while disabled
    for (int i = 0; i < 16; i++) begin
      sent[i] = 8'((i * 37 + 5) & 255);
      busWrite(A_DATA, {8'h00, sent[i]});
    end
    busRead(A_FLAG, v); check("R6 R8 full and busy after 16 writes", v, 'h28);
    busWrite(A_DATA, 16'h00EE);

    // R5 enable without transmit enable
    busWrite(A_CTRL, 16'h0001);
    stayHigh(300, "R5 no frame without transmit enable");
    busRead(A_FLAG, v); check("R5 buffer untouched", v, 'h28);
    // R4 writes while enabled are ignored
    busWrite(A_IDIV, 16'd7); busWrite(A_LINE, 16'h0000); busWrite(A_FDIV, 16'd9);
    busRead(A_IDIV, v); check("R4 locked int divisor", v, 3);
    busRead(A_LINE, v); check("R4 locked line control", v, 'h70);
    busRead(A_FDIV, v); check("R4 locked frac divisor", v, 0);
    busRead(A_FLAG, v); check("R4 R9 no flush while locked", v, 'h28);

    // R2 R11 drain back to back
    busWrite(A_CTRL, 16'h0101);
    for (int i = 0; i < 16; i++) begin
      rxFrame(3, 3, 0, 1'b0, d, fr, pre, post, endAt);
      check("R2 R11 byte order and value", d, int'(sent[i]));
      check("R2 framing bits", fr, 1);
      if (i == 0) begin
        check("R3 start bit before tick 16", pre, 0);
        check("R3 first data bit at tick 16", post, 1);
      end
    end
    stayHigh(2000, "R7 discarded byte not sent");
    busRead(A_FLAG, v); check("R8 busy clears when drained", v, 0);

    // R9 flush, R6 single slot
    busWrite(A_CTRL, 16'h0000);
    busWrite(A_DATA, 16'h0011); busWrite(A_DATA, 16'h0022); busWrite(A_DATA, 16'h0033);
    busRead(A_FLAG, v); check("R8 busy with buffered bytes", v, 'h08);
    busWrite(A_LINE, 16'h0060);
    busRead(A_FLAG, v); check("R9 flush empties buffer", v, 0);
    busWrite(A_DATA, 16'h005A);
    busRead(A_FLAG, v); check("R6 single slot full", v, 'h28);
    busWrite(A_DATA, 16'h00A5);
    busWrite(A_CTRL, 16'h0101);
    rxFrame(3, 3, 0, 1'b0, d, fr, pre, post, endAt);
    check("R6 single slot byte sent", d, 'h5A);
    stayHigh(1000, "R7 single slot overflow discarded");
    busWrite(A_CTRL, 16'h0000);

    // R10 disable during a frame
    busWrite(A_LINE, 16'h0070);
    busWrite(A_DATA, 16'h00C3); busWrite(A_DATA, 16'h003C);
    busWrite(A_CTRL, 16'h0101);
    fork
      rxFrame(3, 3, 0, 1'b0, d, fr, pre, post, endAt);
      begin
        do @(negedge clk); while (txOut !== 1'b0);
        repeat (40) @(negedge clk);
        busWrite(A_CTRL, 16'h0000);
        busWrite(A_IDIV, 16'd9);
        busRead(A_IDIV, v);
        check("R4 locked while frame completes", v, 3);
      end
    join
    check("R10 frame finishes after disable", d, 'hC3);
    check("R10 framing intact", fr, 1);
    stayHigh(1500, "R10 no new frame while disabled");
    busRead(A_FLAG, v); check("R10 remaining byte kept", v, 'h08);
    busWrite(A_IDIV, 16'd4);
    busRead(A_IDIV, v); check("R4 unlocked after frame", v, 4);
    busWrite(A_LINE, 16'h0000);

    // R2 R3 directed and random divisors and word lengths
    for (int k = 0; k < 12; k++) begin
      int iDiv, fDiv, wl, b;
      if (k == 0) begin iDiv = 0; fDiv = 0; wl = 3; b = 'hA6; end
      else if (k == 1) begin iDiv = 1; fDiv = 63; wl = 0; b = 'h35; end
      else if (k == 2) begin iDiv = 2; fDiv = 37; wl = 2; b = 'hFF; end
      else begin
        iDiv = 1 + int'($urandom % 4); fDiv = int'($urandom % 64);
        wl = int'($urandom % 4); b = int'($urandom % 256);
      end
      busWrite(A_CTRL, 16'h0000);
      busWrite(A_IDIV, 16'(iDiv)); busWrite(A_FDIV, 16'(fDiv));
      busWrite(A_LINE, 16'((wl << 5) | 16));
      busWrite(A_DATA, 16'(b));
      busWrite(A_CTRL, 16'h0101);
      rxFrame(wl, iDiv, fDiv, 1'b1, d, fr, pre, post, endAt);
      check("R2 data bits for word length", d, b & ((1 << (wl + 5)) - 1));
      check("R2 start and stop bits", fr, 1);
      check("R3 frame length in clocks", endAt, tickTime(16 * (wl + 7), iDiv, fDiv));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule